// File: doc/BRIEF.md
# System control register bank

A word-addressed control register bank for a small SoC. It sits on a simple 32-bit read/write bus and provides general-purpose input, output and input-change interrupt enables. It also has a command register for the device configuration port that can ask the chip to shut down, and a debug scratchpad guarded by a sticky write lock. Fixed, read-only words report the clock frequency, a capability mask and the system identifier. Writing the identifier word asks the system for a reset.

Two timer instances live outside this block. The bank decodes their address windows and steers the access to them through a one-hot select, a register index and a write flag, and it returns their read data on the shared read bus. Read data is registered: a read presented before a clock edge appears on `bus_rdata_o` after that edge. The bank only accepts full-word accesses.

Top module: `sysctl_bank`

## Requirements
- R1: After reset the general-purpose input word reads the strapping value (default 0x00000001), the configuration-port word reads 1, the frequency word reads 80000000, the capability word reads 0, the identifier word reads 0x10014D31, all other words read 0, and `gpio_o`, `gpio_irq_o`, `shutdown_req_o` and `reset_req_o` are low.
- R2: Only accesses with `bus_size_i` = 2'b10 (word) take effect. Any other size writes nothing, and a read of that size returns 0. The word index is `bus_addr_i[6:2]`, and the two low address bits are ignored.
- R3: The output word (offset 0x04) and the interrupt-enable word (offset 0x08) can be written and read back in their low GPIO_W bits. `gpio_o` follows the output word one cycle after the write.
- R4: Writes to the input word (0x00), the frequency word (0x74) and the capability word (0x78) change nothing.
- R5: The input word reads `gpio_i` through a two-flop synchroniser, so a change first appears in a read captured on the third clock edge after it.
- R6: `gpio_irq_o` pulses high for one cycle, three edges after a change of an input bit whose enable bit is set. A change of a disabled bit raises no pulse.
- R7: Any write to the lock word (0x54) sets it to 1 whatever the data. The scratchpad (0x50) can be written until the lock is set and ignores writes afterwards. Only reset clears the lock.
- R8: A write to the configuration-port word (0x40) whose data bits [15:0] equal 0x000E raises `shutdown_req_o` for the one cycle after the write. Other data raises no request, and the word keeps reading 1.
- R9: A write to the identifier word (0x7C) raises `reset_req_o` for the one cycle after the write and leaves the word unchanged.
- R10: Word accesses at 0x10–0x18 assert `tmr_sel_o[0]` and those at 0x20–0x28 assert `tmr_sel_o[1]`. Meanwhile `tmr_idx_o` is the word index within the window (0 to 2) and `tmr_we_o` follows `bus_we_i`. A read returns that timer's slice of `tmr_rdata_i` (timer 0 in bits [31:0]).
- R11: Reads of unmapped words return 0, and writes to them have no effect on any register or output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_en_i | input | 1 | Access strobe for this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | Access size, 2'b10 = word |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| gpio_i | input | GPIO_W | Asynchronous general-purpose inputs |
| gpio_o | output | GPIO_W | General-purpose outputs |
| gpio_irq_o | output | 1 | Input-change interrupt pulse |
| tmr_sel_o | output | N_TMR | One-hot timer window select |
| tmr_we_o | output | 1 | Write flag for the selected timer |
| tmr_idx_o | output | 2 | Register index inside the timer window |
| tmr_rdata_i | input | N_TMR*32 | Read data of the timers, timer 0 lowest |
| shutdown_req_o | output | 1 | Shutdown request pulse |
| reset_req_o | output | 1 | System reset request pulse |

## Verification
The input-change interrupt and the bus path can act in the same cycle. The bench enables one input bit and toggles a disabled bit and an enabled bit in turn. It then reads back the input word while the change is still crossing the synchroniser. It judges the pulse by its exact cycle and count, and the read by the stale-then-new sequence the two flops impose. The shutdown and reset request strobes are also checked in the very cycle after their writes, with the other strobe required low in that same cycle.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  // word indices (byte offset >> 2)
  localparam int unsigned W_GPIO_IN  = 0;
  localparam int unsigned W_GPIO_OUT = 1;
  localparam int unsigned W_GPIO_EN  = 2;
  localparam int unsigned W_CFG_CMD  = 16;
  localparam int unsigned W_SCRATCH  = 20;
  localparam int unsigned W_LOCK     = 21;
  localparam int unsigned W_FREQ     = 29;
  localparam int unsigned W_CAPS     = 30;
  localparam int unsigned W_SYSID    = 31;

  localparam logic [15:0] CMD_SHUTDOWN = 16'h000E;

  typedef struct packed {
    logic gpio_in;
    logic gpio_out;
    logic gpio_en;
    logic cfg_cmd;
    logic scratch;
    logic lock;
    logic freq;
    logic caps;
    logic sysid;
  } reg_sel_t;
endpackage

// File: rtl/sysctl_addr_dec.sv
module sysctl_addr_dec
  import sysctl_pkg::*;
#(
  parameter int unsigned WORD_W     = 5,
  parameter int unsigned N_TMR      = 2,
  parameter int unsigned TMR_BASE   = 4,
  parameter int unsigned TMR_STRIDE = 4,
  parameter int unsigned TMR_REGS   = 3
) (
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  output reg_sel_t          sel_o,
  output logic [N_TMR-1:0]  tmr_sel_o
);
  logic [31:0] word32;
  assign word32 = 32'(word_i);

  always_comb begin
    sel_o = '0;
    if (valid_i) begin
      case (word32)
        32'(W_GPIO_IN):  sel_o.gpio_in  = 1'b1;
        32'(W_GPIO_OUT): sel_o.gpio_out = 1'b1;
        32'(W_GPIO_EN):  sel_o.gpio_en  = 1'b1;
        32'(W_CFG_CMD):  sel_o.cfg_cmd  = 1'b1;
        32'(W_SCRATCH):  sel_o.scratch  = 1'b1;
        32'(W_LOCK):     sel_o.lock     = 1'b1;
        32'(W_FREQ):     sel_o.freq     = 1'b1;
        32'(W_CAPS):     sel_o.caps     = 1'b1;
        32'(W_SYSID):    sel_o.sysid    = 1'b1;
        default:         sel_o          = '0;
      endcase
    end
  end

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    localparam int unsigned BASE = TMR_BASE + (g + 1) * TMR_STRIDE - TMR_STRIDE;
    assign tmr_sel_o[g] = valid_i && (word32 >= 32'(BASE)) && (word32 < 32'(BASE + TMR_REGS));
  end
endmodule

// File: rtl/sysctl_gpio.sv
module sysctl_gpio #(
  parameter int unsigned GPIO_W = 8,
  parameter logic [GPIO_W-1:0] STRAP = GPIO_W'(1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [GPIO_W-1:0] gpio_i,
  input  logic              we_out_i,
  input  logic              we_en_i,
  input  logic [GPIO_W-1:0] wdata_i,
  output logic [GPIO_W-1:0] in_sync_o,
  output logic [GPIO_W-1:0] out_o,
  output logic [GPIO_W-1:0] en_o,
  output logic              irq_o
);
  logic [GPIO_W-1:0] meta_q, sync_q, prev_q, out_q, en_q;
  logic              irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= STRAP;
      sync_q <= STRAP;
      prev_q <= STRAP;
      irq_q  <= 1'b0;
    end else begin
      meta_q <= gpio_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
      irq_q  <= |((sync_q ^ prev_q) & en_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      en_q  <= '0;
    end else begin
      if (we_out_i) out_q <= wdata_i;
      if (we_en_i)  en_q  <= wdata_i;
    end
  end

  assign in_sync_o = sync_q;
  assign out_o     = out_q;
  assign en_o      = en_q;
  assign irq_o     = irq_q;

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|en_q)); // R6
endmodule

// File: rtl/sysctl_dbg.sv
module sysctl_dbg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_scratch_i,
  input  logic              we_lock_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] scratch_o,
  output logic              lock_o
);
  logic [DATA_W-1:0] scratch_q;
  logic              lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q <= '0;
      lock_q    <= 1'b0;
    end else begin
      if (we_scratch_i && !lock_q) scratch_q <= wdata_i;
      if (we_lock_i)               lock_q    <= 1'b1; // data ignored
    end
  end

  assign scratch_o = scratch_q;
  assign lock_o    = lock_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R7
  AST_SCRATCH_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(scratch_q)); // R7
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned GPIO_W   = 8,
  parameter int unsigned N_TMR    = 2,
  parameter logic [GPIO_W-1:0] GPIO_STRAP = GPIO_W'(1),
  parameter logic [31:0] CLK_HZ   = 32'd80_000_000,
  parameter logic [31:0] CAPS     = 32'h0000_0000,
  parameter logic [31:0] SYS_ID   = 32'h1001_4D31
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bus_en_i,
  input  logic                bus_we_i,
  input  logic [1:0]          bus_size_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [31:0]         bus_wdata_i,
  output logic [31:0]         bus_rdata_o,
  input  logic [GPIO_W-1:0]   gpio_i,
  output logic [GPIO_W-1:0]   gpio_o,
  output logic                gpio_irq_o,
  output logic [N_TMR-1:0]    tmr_sel_o,
  output logic                tmr_we_o,
  output logic [1:0]          tmr_idx_o,
  input  logic [N_TMR*32-1:0] tmr_rdata_i,
  output logic                shutdown_req_o,
  output logic                reset_req_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic              valid, wr, rd;
  logic [WORD_W-1:0] word;
  logic [1:0]        unused_byte_lane;
  reg_sel_t          sel;
  logic [GPIO_W-1:0] gpio_in, gpio_en;
  logic [31:0]       scratch, rd_mux, rdata_q;
  logic              lock, shdn_q, rstreq_q;

  assign valid            = bus_en_i && (bus_size_i == SZ_WORD);
  assign wr               = valid && bus_we_i;
  assign rd               = valid && !bus_we_i;
  assign word             = bus_addr_i[ADDR_W-1:2];
  assign unused_byte_lane = bus_addr_i[1:0];

  sysctl_addr_dec #(.WORD_W(WORD_W), .N_TMR(N_TMR)) u_dec (
    .valid_i   (valid),
    .word_i    (word),
    .sel_o     (sel),
    .tmr_sel_o (tmr_sel_o)
  );

  // timer windows are 4-word aligned
  assign tmr_idx_o = word[1:0];
  assign tmr_we_o  = bus_we_i;

  sysctl_gpio #(.GPIO_W(GPIO_W), .STRAP(GPIO_STRAP)) u_gpio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .gpio_i    (gpio_i),
    .we_out_i  (sel.gpio_out && bus_we_i),
    .we_en_i   (sel.gpio_en && bus_we_i),
    .wdata_i   (bus_wdata_i[GPIO_W-1:0]),
    .in_sync_o (gpio_in),
    .out_o     (gpio_o),
    .en_o      (gpio_en),
    .irq_o     (gpio_irq_o)
  );

  sysctl_dbg #(.DATA_W(32)) u_dbg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .we_scratch_i (sel.scratch && bus_we_i),
    .we_lock_i    (sel.lock && bus_we_i),
    .wdata_i      (bus_wdata_i),
    .scratch_o    (scratch),
    .lock_o       (lock)
  );

  always_comb begin
    rd_mux = '0;
    if (sel.gpio_in)  rd_mux = 32'(gpio_in);
    if (sel.gpio_out) rd_mux = 32'(gpio_o);
    if (sel.gpio_en)  rd_mux = 32'(gpio_en);
    if (sel.cfg_cmd)  rd_mux = 32'd1; // port always ready
    if (sel.scratch)  rd_mux = scratch;
    if (sel.lock)     rd_mux = 32'(lock);
    if (sel.freq)     rd_mux = CLK_HZ;
    if (sel.caps)     rd_mux = CAPS;
    if (sel.sysid)    rd_mux = SYS_ID;
    for (int i = 0; i < N_TMR; i++) begin
      if (tmr_sel_o[i]) rd_mux = tmr_rdata_i[i*32 +: 32];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      shdn_q   <= 1'b0;
      rstreq_q <= 1'b0;
    end else begin
      rdata_q  <= rd ? rd_mux : '0;
      shdn_q   <= wr && sel.cfg_cmd && (bus_wdata_i[15:0] == CMD_SHUTDOWN);
      rstreq_q <= wr && sel.sysid;
    end
  end

  assign bus_rdata_o    = rdata_q;
  assign shutdown_req_o = shdn_q;
  assign reset_req_o    = rstreq_q;

  AST_SHDN_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_req_o |-> $past(bus_en_i && bus_we_i && bus_size_i == SZ_WORD)); // R8
  AST_RSTREQ_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_o |-> $past(bus_en_i && bus_we_i && bus_size_i == SZ_WORD)); // R9
  AST_TMR_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tmr_sel_o)); // R10
endmodule

// File: tb/sysctl_bank_tb.sv
module sysctl_bank_tb;
  localparam logic [31:0] EXP_ID   = 32'h1001_4D31;
  localparam logic [31:0] EXP_FREQ = 32'd80_000_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'b10;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  gpio_in = 8'h01;
  logic [7:0]  gpio_out;
  logic        irq, shdn, rstreq, twe;
  logic [1:0]  tsel, tidx;
  logic [63:0] trdata;

  int checks = 0, errors = 0, irq_cnt = 0;
  logic        rd_issue = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk; // 125 MHz

  assign trdata = {32'hB100_0000 | 32'(tidx), 32'hA000_0000 | 32'(tidx)};

  sysctl_bank u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en), .bus_we_i(we), .bus_size_i(size),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .gpio_i(gpio_in), .gpio_o(gpio_out), .gpio_irq_o(irq),
    .tmr_sel_o(tsel), .tmr_we_o(twe), .tmr_idx_o(tidx), .tmr_rdata_i(trdata),
    .shutdown_req_o(shdn), .reset_req_o(rstreq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compares registered read data after the capturing edge
  always @(posedge clk) begin
    #2;
    if (irq) irq_cnt++;
    if (rd_issue && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rdata === e, t, rdata, e);
    end
  end

  task automatic wr(input logic [6:0] a, input logic [31:0] d, input logic [1:0] s = 2'b10);
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = a; wdata = d; size = s;
    @(negedge clk);
    en = 1'b0; we = 1'b0; size = 2'b10;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] e, input string t, input logic [1:0] s = 2'b10);
    @(negedge clk);
    en = 1'b1; we = 1'b0; addr = a; size = s;
    exp_q.push_back(e); tag_q.push_back(t);
    rd_issue = 1'b1;
    @(negedge clk);
    en = 1'b0; rd_issue = 1'b0; size = 2'b10;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    idle(3);
    chk({gpio_out, irq, shdn, rstreq} === '0, "R1 outputs at reset", 32'({gpio_out, irq, shdn, rstreq}), 0);
    rst_n = 1'b1;
    idle(1);
    // R1 reset values
    rd(7'h00, 32'h1, "R1 gpio in strap");
    rd(7'h04, 0, "R1 gpio out");
    rd(7'h08, 0, "R1 gpio en");
    rd(7'h40, 1, "R1 cfg ready");
    rd(7'h50, 0, "R1 scratch");
    rd(7'h54, 0, "R1 lock");
    rd(7'h74, EXP_FREQ, "R1 freq");
    rd(7'h78, 0, "R1 caps");
    rd(7'h7C, EXP_ID, "R1 sysid");

    // R3 read/write gpio out and enable
    wr(7'h04, 32'h5A);
    chk(gpio_out === 8'h5A, "R3 gpio_o follows", 32'(gpio_out), 32'h5A);
    rd(7'h04, 32'h5A, "R3 gpio out readback");
    wr(7'h04, 32'hFFFF_FF3C);
    rd(7'h04, 32'h3C, "R3 gpio out width");
    wr(7'h08, 32'h80);
    rd(7'h08, 32'h80, "R3 gpio en readback");
    wr(7'h08, 32'h0);

    // R4 read-only words
    wr(7'h00, 32'hFFFF_FFFF);
    wr(7'h74, 32'h1234_5678);
    wr(7'h78, 32'hFFFF_FFFF);
    rd(7'h00, 32'h1, "R4 gpio in read-only");
    rd(7'h74, EXP_FREQ, "R4 freq read-only");
    rd(7'h78, 0, "R4 caps read-only");

    // R5 synchroniser latency: stale, stale, new
    @(negedge clk); gpio_in = 8'h81;
    en = 1'b1; we = 1'b0; addr = 7'h00; size = 2'b10;
    exp_q.push_back(32'h01); tag_q.push_back("R5 sync edge1");
    rd_issue = 1'b1;
    @(negedge clk);
    exp_q.push_back(32'h01); tag_q.push_back("R5 sync edge2");
    @(negedge clk);
    exp_q.push_back(32'h81); tag_q.push_back("R5 sync edge3");
    @(negedge clk);
    en = 1'b0; rd_issue = 1'b0;
    idle(4);

    // R6 interrupt only for enabled bits, exact cycle and single pulse
    wr(7'h08, 32'h01);
    idle(3);
    base = irq_cnt;
    @(negedge clk); gpio_in = 8'h01; // disabled bit 7 changes
    idle(6);
    chk(irq_cnt == base, "R6 disabled bit no irq", 32'(irq_cnt - base), 0);
    @(negedge clk); gpio_in = 8'h00; // enabled bit 0 changes
    @(negedge clk);
    chk(irq === 1'b0, "R6 no irq after edge1", 32'(irq), 0);
    @(negedge clk);
    chk(irq === 1'b0, "R6 no irq after edge2", 32'(irq), 0);
    @(negedge clk);
    chk(irq === 1'b1, "R6 irq after edge3", 32'(irq), 1);
    @(negedge clk);
    chk(irq === 1'b0, "R6 irq one cycle", 32'(irq), 0);
    idle(3);
    chk(irq_cnt == base + 1, "R6 single pulse", 32'(irq_cnt - base), 1);

    // R7 scratchpad and lock; R2 non-word access
    wr(7'h50, 32'hDEAD_BEEF);
    rd(7'h50, 32'hDEAD_BEEF, "R7 scratch writable");
    wr(7'h50, 32'h1111_1111, 2'b01);
    rd(7'h50, 32'hDEAD_BEEF, "R2 half write ignored");
    rd(7'h7C, 32'h0, "R2 byte read zero", 2'b00);
    chk(rstreq === 1'b0, "R2 no reset req on read", 32'(rstreq), 0);
    wr(7'h7C, 32'h0, 2'b01);
    chk(rstreq === 1'b0, "R2 non-word id write no req", 32'(rstreq), 0);
    rd(7'h7E, EXP_ID, "R2 low address bits ignored");
    wr(7'h54, 32'h0);
    rd(7'h54, 32'h1, "R7 lock set by any data");
    wr(7'h50, 32'h1234_5678);
    rd(7'h50, 32'hDEAD_BEEF, "R7 scratch locked");
    wr(7'h54, 32'h0);
    rd(7'h54, 32'h1, "R7 lock stays");

    // R8 shutdown command
    wr(7'h40, 32'h0001_000E);
    chk(shdn === 1'b1, "R8 shutdown pulse", 32'(shdn), 1);
    chk(rstreq === 1'b0, "R8 no reset with shutdown", 32'(rstreq), 0);
    @(negedge clk);
    chk(shdn === 1'b0, "R8 shutdown one cycle", 32'(shdn), 0);
    wr(7'h40, 32'h0000_000F);
    chk(shdn === 1'b0, "R8 other code no shutdown", 32'(shdn), 0);
    rd(7'h40, 32'h1, "R8 cfg reads ready");

    // R9 reset request
    wr(7'h7C, 32'hFFFF_FFFF);
    chk(rstreq === 1'b1, "R9 reset pulse", 32'(rstreq), 1);
    chk(shdn === 1'b0, "R9 no shutdown with reset", 32'(shdn), 0);
    @(negedge clk);
    chk(rstreq === 1'b0, "R9 reset one cycle", 32'(rstreq), 0);
    rd(7'h7C, EXP_ID, "R9 id unchanged");

    // R10 timer windows
    @(negedge clk);
    en = 1'b1; we = 1'b0; addr = 7'h14; size = 2'b10;
    #1;
    chk(tsel === 2'b01 && tidx === 2'd1 && twe === 1'b0, "R10 timer0 decode", 32'({tsel, tidx, twe}), 32'({2'b01, 2'd1, 1'b0}));
    exp_q.push_back(32'hA000_0001); tag_q.push_back("R10 timer0 read");
    rd_issue = 1'b1;
    @(negedge clk);
    en = 1'b0; rd_issue = 1'b0;
    @(negedge clk);
    en = 1'b1; we = 1'b1; addr = 7'h20; wdata = 32'h5;
    #1;
    chk(tsel === 2'b10 && tidx === 2'd0 && twe === 1'b1, "R10 timer1 write decode", 32'({tsel, tidx, twe}), 32'({2'b10, 2'd0, 1'b1}));
    @(negedge clk);
    en = 1'b0; we = 1'b0;
    rd(7'h28, 32'hB100_0002, "R10 timer1 read");
    @(negedge clk);
    en = 1'b1; addr = 7'h1C;
    #1;
    chk(tsel === 2'b00, "R11 gap after timer0 no select", 32'(tsel), 0);
    @(negedge clk);
    en = 1'b0;

    // R11 unmapped
    rd(7'h1C, 0, "R11 unmapped 0x1C");
    rd(7'h0C, 0, "R11 unmapped 0x0C");
    wr(7'h60, 32'hFFFF_FFFF);
    chk({shdn, rstreq} === 2'b00, "R11 unmapped write no pulse", 32'({shdn, rstreq}), 0);
    rd(7'h60, 0, "R11 unmapped 0x60");
    rd(7'h04, 32'h3C, "R11 gpio out untouched");
    rd(7'h50, 32'hDEAD_BEEF, "R11 scratch untouched");

    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule